// File: doc/BRIEF.md
# Packed-Lane Integer ALU

A combinational arithmetic-logic unit for a 32-bit datapath. The same word is read either as one 32-bit integer or as four independent 8-bit lanes. An operation code picks one of ten functions: scalar and lane-wise add, scalar and lane-wise negate, three bitwise logic functions, a whole-word nonzero test, a per-lane nonzero test, and a shift. In the shift, the sign of the second operand sets the direction.

The unit is meant to sit in an execute stage between operand read and write-back. It has no clock and no state, and the result follows the inputs. The scalar and lane-wise add and negate share one carry chain, which is cut at the byte boundaries in lane mode. Lane 0 is bits 7:0 and lane 3 is bits 31:24.

Top module: `swar_alu`

## Requirements
- R1: Op code 0 (scalar add) gives (s + t) mod 2^32.
- R2: Op code 1 (lane add) gives, for each lane i in bits 8i+7:8i, (s_i + t_i) mod 256. No carry passes from one lane into the next.
- R3: Op code 2 (scalar negate) gives the two's-complement negation of s, mod 2^32.
- R4: Op code 3 (lane negate) gives (256 - s_i) mod 256 in each lane, with no borrow across lanes.
- R5: Op codes 4, 5 and 6 give the bitwise AND, OR and XOR of the full 32-bit s and t.
- R6: Op code 7 (any) gives 32'h1 when s is nonzero and 32'h0 when s is zero.
- R7: Op code 8 (lane any) sets each lane to 8'h01 when the matching lane of s is nonzero, and to 8'h00 otherwise.
- R8: Op code 9 (shift) with t read as a signed value of 0 or more gives s shifted left by t. For t of 32 or more the result is 0.
- R9: Op code 9 with a negative t gives s shifted arithmetically right by -t, with sign fill. For -t of 32 or more, every bit of the result equals bit 31 of s.
- R10: Op codes 10 to 15 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_in | input | 32 | First operand |
| t_in | input | 32 | Second operand; a signed shift amount for op 9 |
| op_in | input | 4 | Operation code |
| res_out | output | 32 | Result |

## Verification
The add and negate operations are swept over a grid of byte values: 00, 01, 7F, 80, FF and a few in between. The grid is placed in every lane at once and in single lanes. This separates a chain that leaks carries across lane boundaries from a correct one, and it also separates a scalar path that wrongly cuts its carries. The nonzero tests get words with exactly one nonzero lane in each position, and the zero word, so a swapped or merged lane shows up. The shift is swept over every amount from -40 to 40 and both extreme amounts, with positive and negative operands. This covers direction, sign fill and the saturation at 32.

// File: rtl/swar_pkg.sv
package swar_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDV = 4'd1,
    OP_NEG  = 4'd2,
    OP_NEGV = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_ANY  = 4'd7,
    OP_ANYV = 4'd8,
    OP_SHF  = 4'd9
  } swar_op_e;

  // True for the operations that use the shared add/negate chain
  function automatic logic uses_chain(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_ADDV) || (op == OP_NEG) || (op == OP_NEGV);
  endfunction
endpackage

// File: rtl/swar_addsub.sv
module swar_addsub #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int W = LANE_W * LANES
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         neg_in,   // 1: compute 0 - a
  input  logic         vec_in,   // 1: cut carries at lane boundaries
  output logic [W-1:0] sum_out,
  output logic         top_cout  // carry out of the top lane
);
  logic [LANES:0] carry;
  assign carry[0] = neg_in;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] x, y;
    logic              cin;
    assign x   = neg_in ? '0 : a_in[i*LANE_W +: LANE_W];
    assign y   = neg_in ? ~a_in[i*LANE_W +: LANE_W] : b_in[i*LANE_W +: LANE_W];
    assign cin = (vec_in || i == 0) ? neg_in : carry[i];
    assign {carry[i+1], sum_out[i*LANE_W +: LANE_W]} =
      {1'b0, x} + {1'b0, y} + {{LANE_W{1'b0}}, cin};
  end

  assign top_cout = carry[LANES];

  always_comb begin
    // R3
    if (!vec_in && neg_in) neg_sum_chk: assert (sum_out + a_in == '0);
  end
endmodule

// File: rtl/swar_reduce.sv
module swar_reduce #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int W = LANE_W * LANES
) (
  input  logic [W-1:0] s_in,
  output logic [W-1:0] any_out,
  output logic [W-1:0] anyv_out
);
  logic [LANES-1:0] lane_nz;

  for (genvar i = 0; i < LANES; i++) begin : g_nz
    assign lane_nz[i] = |s_in[i*LANE_W +: LANE_W];
    assign anyv_out[i*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, lane_nz[i]};
  end

  assign any_out = {{(W-1){1'b0}}, |lane_nz};

  always_comb begin
    // R6
    any_zero_chk: assert ((any_out == '0) == (s_in == '0));
  end
endmodule

// File: rtl/swar_shift.sv
module swar_shift #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] t_in,
  output logic [W-1:0] sh_out
);
  logic         go_right;
  logic [W:0]   mag;
  logic         too_far;
  logic [SHW-1:0] amt;

  assign go_right = t_in[W-1];
  assign mag      = go_right ? ({1'b0, ~t_in} + 1'b1) : {1'b0, t_in};
  assign too_far  = mag >= (W+1)'(W);
  assign amt      = mag[SHW-1:0];

  always_comb begin
    if (go_right)
      sh_out = too_far ? {W{s_in[W-1]}} : W'($signed(s_in) >>> amt);
    else
      sh_out = too_far ? '0 : (s_in << amt);
  end

  always_comb begin
    // R8
    if (!go_right && too_far) left_sat_chk: assert (sh_out == '0);
    // R9
    if (go_right) right_sign_chk: assert (sh_out[W-1] == s_in[W-1]);
  end
endmodule

// File: rtl/swar_alu.sv
module swar_alu #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int W = LANE_W * LANES
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] t_in,
  input  logic [3:0]   op_in,
  output logic [W-1:0] res_out
);
  import swar_pkg::*;

  logic [W-1:0] chain_sum, any_r, anyv_r, sh_r;
  logic         chain_cout, chain_neg, chain_vec;

  assign chain_neg = (op_in == OP_NEG) || (op_in == OP_NEGV);
  assign chain_vec = (op_in == OP_ADDV) || (op_in == OP_NEGV);

  swar_addsub #(.LANE_W(LANE_W), .LANES(LANES)) u_addsub (
    .a_in(s_in), .b_in(t_in), .neg_in(chain_neg), .vec_in(chain_vec),
    .sum_out(chain_sum), .top_cout(chain_cout)
  );

  swar_reduce #(.LANE_W(LANE_W), .LANES(LANES)) u_reduce (
    .s_in(s_in), .any_out(any_r), .anyv_out(anyv_r)
  );

  swar_shift #(.W(W)) u_shift (
    .s_in(s_in), .t_in(t_in), .sh_out(sh_r)
  );

  always_comb begin
    if (uses_chain(op_in)) res_out = chain_sum;
    else begin
      case (op_in)
        OP_AND:  res_out = s_in & t_in;
        OP_OR:   res_out = s_in | t_in;
        OP_XOR:  res_out = s_in ^ t_in;
        OP_ANY:  res_out = any_r;
        OP_ANYV: res_out = anyv_r;
        OP_SHF:  res_out = sh_r;
        default: res_out = '0;
      endcase
    end
  end

  always_comb begin
    // R1
    if (op_in == OP_ADD)
      scalar_add_chk: assert ({chain_cout, res_out} == {1'b0, s_in} + {1'b0, t_in});
    // R2
    if (op_in == OP_ADDV)
      lane0_add_chk: assert (res_out[LANE_W-1:0] == LANE_W'(s_in[LANE_W-1:0] + t_in[LANE_W-1:0]));
    // R7
    if (op_in == OP_ANYV)
      for (int i = 0; i < LANES; i++)
        anyv_hi_chk: assert (res_out[i*LANE_W+1 +: LANE_W-1] == '0);
    // R10
    if (op_in > OP_SHF) unused_op_chk: assert (res_out == '0);
  end
endmodule

// File: tb/sim_swar_alu.sv
module sim_swar_alu;
  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic [31:0] s, t, res;
  logic [3:0]  op;
  int checks = 0, errors = 0;
  bit  done = 0;

  swar_alu u0 (.s_in(s), .t_in(t), .op_in(op), .res_out(res));

  byte unsigned grid [8] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};

  function automatic logic [31:0] ref_calc(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    longint sa, amount;
    case (o)
      4'd0: r = 32'((64'(a) + 64'(b)) % 64'h1_0000_0000);
      4'd1: for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'((int'(a[8*k +: 8]) + int'(b[8*k +: 8])) % 256);
      4'd2: r = 32'(64'h1_0000_0000 - 64'(a));
      4'd3: for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'((256 - int'(a[8*k +: 8])) % 256);
      4'd4: for (int k = 0; k < 32; k++) r[k] = a[k] && b[k];
      4'd5: for (int k = 0; k < 32; k++) r[k] = a[k] || b[k];
      4'd6: for (int k = 0; k < 32; k++) r[k] = a[k] != b[k];
      4'd7: r = (a != 0) ? 32'd1 : 32'd0;
      4'd8: for (int k = 0; k < 4; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'd1 : 8'd0;
      4'd9: begin
        amount = longint'($signed(b));
        sa = longint'($signed(a));
        if (amount >= 0) r = (amount >= 32) ? 32'd0 : 32'(64'(a) * (64'd1 << amount));
        else begin
          amount = -amount;
          if (amount > 40) amount = 40;
          r = 32'(sa >>> amount);
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input string req);
    logic [31:0] exp;
    op = o; s = a; t = b;
    #2;
    exp = ref_calc(o, a, b);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d s=%h t=%h actual=%h expected=%h", req, o, a, b, res, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op = 0; s = 0; t = 0;
    repeat (2) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // reset-time state: add of zeros
    chk(4'd0, 32'd0, 32'd0, "R1");
    // lane grids: every lane and single lanes
    foreach (grid[i]) foreach (grid[j]) begin
      logic [31:0] a4 = {4{grid[i]}}, b4 = {4{grid[j]}};
      chk(4'd0, a4, b4, "R1");
      chk(4'd1, a4, b4, "R2");
      chk(4'd1, {grid[i], 8'hFF, grid[j], 8'h01}, {grid[j], 8'h01, grid[i], 8'hFF}, "R2");
      chk(4'd5, a4, {grid[j], 24'h5A0F33}, "R5");
      chk(4'd4, a4, {grid[j], 24'h5A0F33}, "R5");
      chk(4'd6, a4, {grid[j], 24'h5A0F33}, "R5");
    end
    foreach (grid[i]) for (int ln = 0; ln < 4; ln++) begin
      logic [31:0] one = 32'(grid[i]) << (8*ln);
      chk(4'd2, one, 0, "R3");
      chk(4'd3, one, 0, "R4");
      chk(4'd3, {4{grid[i]}}, 0, "R4");
      chk(4'd7, one, 0, "R6");
      chk(4'd8, one, 0, "R7");
      chk(4'd8, one | 32'h0100_0000, 0, "R7");
    end
    chk(4'd2, 32'h8000_0000, 0, "R3");
    chk(4'd0, 32'hFFFF_FFFF, 32'd1, "R1");
    // shift sweep
    for (int a = -40; a <= 40; a++) begin
      chk(4'd9, 32'h8123_4567, 32'(a), a < 0 ? "R9" : "R8");
      chk(4'd9, 32'h0F00_00F1, 32'(a), a < 0 ? "R9" : "R8");
      chk(4'd9, 32'hFFFF_FFFF, 32'(a), a < 0 ? "R9" : "R8");
    end
    chk(4'd9, 32'h8000_0001, 32'h8000_0000, "R9");
    chk(4'd9, 32'h7000_0001, 32'h8000_0000, "R9");
    chk(4'd9, 32'h0000_0001, 32'h7FFF_FFFF, "R8");
    for (int o = 10; o < 16; o++) chk(4'(o), 32'hDEAD_BEEF, 32'h0000_0003, "R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule